// File: doc/BRIEF.md
# Bus Master Termination and Retry Controller

This block runs one bus transfer at a time for a single bus master. A transfer is accepted on a request interface while the controller is idle. The request carries an address, attribute bits, write data and a direction flag, and these values are latched. The controller then wins the bus, either by checking that the bus is free itself (internal-arbiter mode) or by raising a bus request and waiting for a grant (external-arbiter mode). It drives bus-busy and a one-cycle transfer-start strobe, and then watches three termination inputs.

Acknowledge completes the transfer normally. Transfer error ends it and sends a one-cycle exception pulse back to the requester. Retry makes the controller release the bus for a cycle, arbitrate again, and replay the same latched transfer. The error input is the OR of several error sources plus an optional no-response monitor. The monitor forces an error when no acknowledge arrives within a programmable number of cycles. After an error the controller waits one extra cycle before it accepts new work, so a slow error release cannot be taken as part of the next transfer.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset the controller is idle: req_ready is 1, and bus_busy_out, bus_req_out, bus_grant_out, ts_out and all three status pulses are 0.
- R2: A request is accepted only while req_ready is 1. A req_valid while busy has no effect: addr_out keeps the latched value, and no second transfer follows the current one.
- R3: With the bus free, ts_out and bus_busy_out rise in the second cycle after the accepting clock edge. ts_out is high only in the first cycle of bus ownership.
- R4: Acknowledge sampled during ownership gives done_pulse for exactly one cycle in the next cycle. In that same cycle bus_busy_out is 0 and req_ready is 1.
- R5: Any bit of err_src sampled during ownership ends the transfer with err_pulse. This holds even when ack_in or retry_in is sampled in the same cycle. No done_pulse or retry_pulse is produced.
- R6: In the cycle that shows err_pulse, req_ready is 0 and err_src is ignored. req_ready returns one cycle later.
- R7: In internal-arbiter mode, retry gives one cycle with bus_busy_out at 0 and bus_grant_out at 1. This is followed by one arbitration cycle. The transfer then restarts with the same address, attributes, write data and direction.
- R8: In external-arbiter mode, bus_req_out is 1 only while arbitrating. Ownership starts only when bus_grant_in is 1 and ext_bb_in is 0. After a retry, bus_req_out and bus_busy_out are both 0 for one cycle, and then bus_req_out rises again.
- R9: While ext_bb_in is 1, the controller does not take the bus. It waits in arbitration with bus_busy_out at 0.
- R10: With to_limit equal to L > 0 and no acknowledge, err_pulse appears L cycles after the transfer-start cycle. With to_limit equal to 0 the monitor never fires.
- R11: Retry takes priority over acknowledge in the same cycle. retry_cnt counts the retries of the current transfer, saturates at its maximum, and clears when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arb_internal | input | 1 | 1: internal-arbiter mode, 0: external-arbiter mode |
| to_limit | input | TOW | No-response timeout in cycles, 0 disables |
| req_valid | input | 1 | New transfer offered |
| req_addr | input | AW | Transfer address |
| req_attr | input | AT | Transfer attributes |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ready | output | 1 | Idle and able to accept |
| done_pulse | output | 1 | Normal completion pulse |
| err_pulse | output | 1 | Exception pulse to requester |
| retry_pulse | output | 1 | Pulse per retry |
| retry_cnt | output | RCW | Retries of the current transfer |
| ext_bb_in | input | 1 | Another master holds the bus |
| bus_grant_in | input | 1 | Grant from external arbiter |
| ack_in | input | 1 | Transfer acknowledge |
| err_src | input | NERR | Error sources, ORed |
| retry_in | input | 1 | Retry termination |
| bus_req_out | output | 1 | Bus request (external mode) |
| bus_grant_out | output | 1 | Bus grant to others (internal mode) |
| bus_busy_out | output | 1 | Controller owns the bus |
| ts_out | output | 1 | Transfer start strobe |
| addr_out | output | AW | Latched address |
| attr_out | output | AT | Latched attributes |
| wdata_out | output | DW | Latched write data |
| write_out | output | 1 | Latched direction |

## Verification
The bench sweeps the acknowledge latency and the monitor limit. It checks that a timeout fires on exactly the Lth cycle, because a counter that is off by one would end transfers a cycle early or late. It presents error, retry and acknowledge together to check the priority order. A design with the wrong order would report completion on a failed bus cycle. It holds the error sources high into the hold cycle, since a controller without that guard would raise a second exception. It replays several retries in both arbiter modes to check the bus release cycle and the replayed address and data. It holds ext_bb_in high after a retry, because a design that grabs the bus anyway would drive while another master owns it.

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl #(
  parameter int AW   = 16,
  parameter int AT   = 4,
  parameter int DW   = 16,
  parameter int NERR = 2,
  parameter int TOW  = 6,
  parameter int RCW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arb_internal,
  input  logic [TOW-1:0]  to_limit,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [AT-1:0]   req_attr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_write,
  output logic            req_ready,
  output logic            done_pulse,
  output logic            err_pulse,
  output logic            retry_pulse,
  output logic [RCW-1:0]  retry_cnt,
  input  logic            ext_bb_in,
  input  logic            bus_grant_in,
  input  logic            ack_in,
  input  logic [NERR-1:0] err_src,
  input  logic            retry_in,
  output logic            bus_req_out,
  output logic            bus_grant_out,
  output logic            bus_busy_out,
  output logic            ts_out,
  output logic [AW-1:0]   addr_out,
  output logic [AT-1:0]   attr_out,
  output logic [DW-1:0]   wdata_out,
  output logic            write_out
);

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_XFER, S_RTRY, S_EHOLD} st_t;

  st_t            st;
  logic [TOW-1:0] cnt;
  logic [TOW:0]   cnt_nx;
  logic           in_xfer, tmo, err_any, win;
  logic           term_err, term_rty, term_ack;

  assign in_xfer  = (st == S_XFER);
  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign tmo      = in_xfer && (to_limit != '0) && (cnt_nx >= {1'b0, to_limit});
  assign err_any  = (|err_src) || tmo;
  assign win      = arb_internal ? !ext_bb_in : (bus_grant_in && !ext_bb_in);
  assign term_err = in_xfer && err_any;
  assign term_rty = in_xfer && !err_any && retry_in;
  assign term_ack = in_xfer && !err_any && !retry_in && ack_in;

  assign req_ready     = (st == S_IDLE);
  assign bus_busy_out  = in_xfer;
  assign ts_out        = in_xfer && (cnt == '0);
  assign bus_grant_out = arb_internal && (st == S_RTRY);
  assign bus_req_out   = !arb_internal && (st == S_ARB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      done_pulse  <= 1'b0;
      err_pulse   <= 1'b0;
      retry_pulse <= 1'b0;
      retry_cnt   <= '0;
      addr_out    <= '0;
      attr_out    <= '0;
      wdata_out   <= '0;
      write_out   <= 1'b0;
    end else begin
      done_pulse  <= 1'b0;
      err_pulse   <= 1'b0;
      retry_pulse <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_out  <= req_addr;
          attr_out  <= req_attr;
          wdata_out <= req_wdata;
          write_out <= req_write;
          retry_cnt <= '0;
          st        <= S_ARB;
        end
        S_ARB: if (win) begin
          cnt <= '0;
          st  <= S_XFER;
        end
        S_XFER: begin
          if (term_err) begin
            err_pulse <= 1'b1;
            st        <= S_EHOLD;
          end else if (term_rty) begin
            retry_pulse <= 1'b1;
            if (retry_cnt != '1) retry_cnt <= retry_cnt + 1'b1;
            st <= S_RTRY;
          end else if (term_ack) begin
            done_pulse <= 1'b1;
            st         <= S_IDLE;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RTRY:  st <= S_ARB;
        S_EHOLD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, err_pulse, retry_pulse}));

  a_r2_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(addr_out) && $stable(wdata_out) && $stable(attr_out));

  a_r3_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |-> bus_busy_out && !req_ready);

  a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !bus_busy_out && req_ready);

  a_r5_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_out && (|err_src) |=> err_pulse && !done_pulse && !retry_pulse);

  a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !req_ready && !bus_busy_out);

  a_r7_int_release: assert property (@(posedge clk) disable iff (!rst_n)
    arb_internal && bus_busy_out && retry_in && !err_any |=> bus_grant_out && !bus_busy_out);

  a_r8_ext_release: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_internal && bus_busy_out && retry_in && !err_any
      |=> !bus_req_out && !bus_busy_out && !bus_grant_out);

  a_r9_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARB) && ext_bb_in |=> !bus_busy_out);

  a_r10_monitor_off: assert property (@(posedge clk) disable iff (!rst_n)
    (to_limit == '0) && bus_busy_out && !(|err_src) |=> !err_pulse);

  a_r11_retry_over_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_out && retry_in && ack_in && !err_any |=> retry_pulse && !done_pulse);

endmodule

// File: tb/bus_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_term_ctrl_tb_top;
  localparam int AW = 16, AT = 4, DW = 16, NERR = 2, TOW = 4, RCW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arb_internal = 1'b1;
  logic [TOW-1:0] to_limit = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AT-1:0] req_attr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ext_bb_in = 1'b0, bus_grant_in = 1'b1, ack_in = 1'b0, retry_in = 1'b0;
  logic [NERR-1:0] err_src = '0;
  logic req_ready, done_pulse, err_pulse, retry_pulse;
  logic [RCW-1:0] retry_cnt;
  logic bus_req_out, bus_grant_out, bus_busy_out, ts_out, write_out;
  logic [AW-1:0] addr_out;
  logic [AT-1:0] attr_out;
  logic [DW-1:0] wdata_out;

  int tests = 0, fails = 0, cyc = 0;

  bus_term_ctrl #(.AW(AW), .AT(AT), .DW(DW), .NERR(NERR), .TOW(TOW), .RCW(RCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arb_internal(arb_internal), .to_limit(to_limit),
    .req_valid(req_valid), .req_addr(req_addr), .req_attr(req_attr), .req_wdata(req_wdata),
    .req_write(req_write), .req_ready(req_ready), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .retry_pulse(retry_pulse), .retry_cnt(retry_cnt), .ext_bb_in(ext_bb_in),
    .bus_grant_in(bus_grant_in), .ack_in(ack_in), .err_src(err_src), .retry_in(retry_in),
    .bus_req_out(bus_req_out), .bus_grant_out(bus_grant_out), .bus_busy_out(bus_busy_out),
    .ts_out(ts_out), .addr_out(addr_out), .attr_out(attr_out), .wdata_out(wdata_out),
    .write_out(write_out));

  always #2 clk = ~clk;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input int a, input int t, input int d, input bit w);
    req_valid = 1'b1; req_addr = AW'(a); req_attr = AT'(t); req_wdata = DW'(d); req_write = w;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic await_ts(output int n);
    n = 0;
    while (!ts_out && n < 60) begin tick(); n++; end
  endtask

  task automatic ack_now();
    ack_in = 1'b1; tick(); ack_in = 1'b0;
  endtask

  initial begin
    int n;
    tick(); tick();
    // R1 reset state
    check("R1 ready", req_ready, 1);
    check("R1 outs", {bus_busy_out, bus_req_out, bus_grant_out, ts_out}, 0);
    check("R1 pulses", {done_pulse, err_pulse, retry_pulse}, 0);
    rst_n = 1'b1;
    tick();

    // R3 / R4: ack latency sweep
    for (int d = 0; d < 5; d++) begin
      issue(16'h100 + d, d, 16'hA000 + d, d[0]);
      check("R3 arb cycle idle bus", {bus_busy_out, ts_out}, 0);
      await_ts(n);
      check("R3 start delay", n, 1);
      check("R3 addr", addr_out, 16'h100 + d);
      for (int i = 0; i < d; i++) begin
        tick();
        check("R3 ts one cycle", {ts_out, done_pulse, bus_busy_out}, 1);
      end
      ack_now();
      check("R4 done", {done_pulse, bus_busy_out, req_ready}, 3'b101);
      tick();
      check("R4 done single", done_pulse, 0);
    end

    // R10 monitor sweep
    for (int lim = 1; lim <= 5; lim++) begin
      to_limit = TOW'(lim);
      issue(16'h200 + lim, 1, 0, 0);
      await_ts(n);
      n = 0;
      while (!err_pulse && n < 40) begin tick(); n++; end
      check("R10 timeout cycles", n, lim);
      check("R6 not ready in err cycle", req_ready, 0);
      tick();
      check("R6 ready after hold", req_ready, 1);
    end
    to_limit = '0;
    issue(16'h2FF, 0, 0, 0);
    await_ts(n);
    n = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (err_pulse) n++; end
    check("R10 disabled no error", n, 0);
    ack_now();
    check("R10 disabled acks", done_pulse, 1);

    // R5 / R6: error beats ack and retry, then lingering error ignored
    for (int b = 0; b < NERR; b++) begin
      issue(16'h300 + b, 2, 16'h55, 1);
      await_ts(n);
      err_src = NERR'(1) << b; ack_in = 1'b1; retry_in = 1'b1;
      tick();
      ack_in = 1'b0; retry_in = 1'b0;
      check("R5 err priority", {err_pulse, done_pulse, retry_pulse}, 3'b100);
      tick();
      check("R6 lingering error ignored", {err_pulse, req_ready}, 2'b01);
      err_src = '0;
      issue(16'h310 + b, 0, 0, 0);
      await_ts(n);
      ack_now();
      check("R6 next transfer clean", {done_pulse, err_pulse}, 2'b10);
    end

    // R7 / R11: internal-arbiter retries with replay
    issue(16'hBEEF, 4'hA, 16'h1234, 1);
    await_ts(n);
    for (int k = 1; k <= 3; k++) begin
      retry_in = 1'b1; ack_in = 1'b1;
      tick();
      retry_in = 1'b0; ack_in = 1'b0;
      check("R11 retry over ack", {retry_pulse, done_pulse}, 2'b10);
      check("R11 retry count", retry_cnt, k);
      check("R7 release grant", {bus_busy_out, bus_grant_out}, 2'b01);
      tick();
      check("R7 arb cycle", {bus_busy_out, bus_grant_out}, 0);
      tick();
      check("R7 restart", ts_out, 1);
      check("R7 replay", {addr_out, attr_out, wdata_out, write_out},
            {16'hBEEF, 4'hA, 16'h1234, 1'b1});
    end
    for (int k = 4; k <= 9; k++) begin
      retry_in = 1'b1; tick(); retry_in = 1'b0;
      tick(); tick();
    end
    check("R11 retry count saturates", retry_cnt, 7);
    ack_now();
    check("R7 done after retries", done_pulse, 1);
    issue(16'h1, 0, 0, 0);
    check("R11 count cleared", retry_cnt, 0);
    await_ts(n);
    ack_now();

    // R9: other master busy after retry
    issue(16'h400, 0, 16'h9, 1);
    await_ts(n);
    retry_in = 1'b1; tick(); retry_in = 1'b0;
    ext_bb_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R9 wait while busy", bus_busy_out, 0);
    end
    ext_bb_in = 1'b0;
    tick();
    check("R9 resume", {ts_out, addr_out}, {1'b1, 16'h400});
    ack_now();

    // R2: request while busy ignored
    issue(16'h500, 3, 16'h77, 0);
    await_ts(n);
    req_valid = 1'b1; req_addr = 16'h5FF;
    tick();
    req_valid = 1'b0;
    check("R2 addr kept", addr_out, 16'h500);
    ack_now();
    check("R2 done", done_pulse, 1);
    tick(); tick();
    check("R2 no second transfer", {req_ready, bus_busy_out}, 2'b10);

    // R8: external arbiter
    arb_internal = 1'b0; bus_grant_in = 1'b0;
    tick();
    issue(16'h600, 5, 16'h42, 1);
    check("R8 request raised", bus_req_out, 1);
    tick(); tick();
    check("R8 waits for grant", {bus_busy_out, bus_req_out}, 2'b01);
    bus_grant_in = 1'b1;
    tick();
    check("R8 owns after grant", {ts_out, bus_req_out}, 2'b10);
    retry_in = 1'b1; tick(); retry_in = 1'b0;
    check("R8 release", {bus_req_out, bus_busy_out, bus_grant_out, retry_pulse}, 4'b0001);
    tick();
    check("R8 re-request", bus_req_out, 1);
    tick();
    check("R8 replay", {ts_out, addr_out, wdata_out}, {1'b1, 16'h600, 16'h42});
    ack_now();
    check("R8 done", done_pulse, 1);

    tick();
    summary();
  end
endmodule